// File: doc/BRIEF.md
# Multifunction Integer ALU with Shifter

This block is the purely combinational execute stage of a small integer datapath. It takes two 32-bit operands, a 5-bit constant shift count and one 8-bit control word, and returns a 32-bit result with a zero flag and a signed-overflow flag. The control word has four fields:

- a function class, which picks the arithmetic, logic or shift section, or a reserved code;
- an add/subtract bit for the single adder;
- a shift field, which gives the shift kind and the source of the shift count;
- a logic field, which picks one of four bitwise functions.

The adder subtracts by inverting the second operand and forcing its carry-in high. The shifter is a cascade of multiplexer stages. Each stage moves the word by a power of two under one bit of the count. The count comes either from the constant input or from the low bits of the first operand. A final multiplexer routes the output of the selected section to the result. There is no state: every output follows its inputs in the same cycle.

Top module: `int_alu_core`

## Requirements
- R1: The control word is split as follows. Bits [7:6] are the class: 00 = arithmetic, 01 = logic, 10 = shift, 11 = reserved. Bit [5] is subtract. Bit [4] selects the shift count source. Bits [3:2] are the shift kind. Bits [1:0] are the logic function. With class 00 and bit 5 clear, the result is opa + opb modulo 2^32.
- R2: With class 00 and bit 5 set, the result is opa - opb modulo 2^32.
- R3: With class 01, the logic field selects the function: 00 = AND, 01 = OR, 10 = XOR, 11 = NOR of opa and opb.
- R4: With class 10, the shift kind gives the operation on opb: 00 = pass opb unchanged, 01 = logical left shift, 10 = logical right shift. Vacated bits are zero-filled, and a count of 0 returns opb unchanged.
- R5: Shift kind 11 is an arithmetic right shift of opb. Vacated high bits take the copy of opb bit 31.
- R6: When control bit 4 is 0, the count is shamt_imm. When it is 1, the count is opa[4:0], and opa[31:5] has no effect.
- R7: Class 11 gives a result of all zeros.
- R8: zero is 1 exactly when the result is all zeros, in every class.
- R9: ovf is 1 only in class 00, and only when the add or subtract overflows in two's complement. In every other class it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl | input | 8 | Control word: class, subtract, shift source, shift kind and logic function |
| opa | input | 32 | First operand; its low 5 bits give the variable shift count |
| opb | input | 32 | Second operand; this is the value that is shifted |
| shamt_imm | input | 5 | Constant shift count |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the add or subtract |

## Verification
Every output is due in the same cycle as the stimulus, because no register sits between the ports. The bench drives each vector just after a rising clock edge. It reads result, zero and ovf at the following falling edge, half a period later, when all combinational paths have settled. A fresh vector is never applied until the previous one has been read.

// File: rtl/alu_pkg.sv
// Package: shared field encodings for the integer ALU control word.
// Assumes the control layout {class[1:0], sub, var_amt, kind[1:0], lfn[1:0]}.
package alu_pkg;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'b00,
        CLS_LOGIC = 2'b01,
        CLS_SHIFT = 2'b10,
        CLS_RSVD  = 2'b11
    } fclass_e;

    typedef enum logic [1:0] {
        SK_NONE = 2'b00,
        SK_SLL  = 2'b01,
        SK_SRL  = 2'b10,
        SK_SRA  = 2'b11
    } shkind_e;

    typedef enum logic [1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_XOR = 2'b10,
        LF_NOR = 2'b11
    } logfn_e;

    typedef struct packed {
        fclass_e cls;
        logic    sub;
        logic    var_amt;
        shkind_e kind;
        logfn_e  lfn;
    } ctrl_t;
endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor: one adder; subtraction inverts opb and forces carry-in high.
// Assumes two's-complement operands of width W; the overflow flag is raw (class gating is done by the top).
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    // Conditional inversion of the second operand.
    always_comb b_eff = sub ? ~b : b;

    // Single carry-propagate add with the subtract bit as carry-in.
    always_comb sum = a + b_eff + {{(W-1){1'b0}}, sub};

    // Signed overflow: operands agree in sign, sum disagrees.
    always_comb ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

    // Guards for the subtract path and the overflow rule.
    always_comb begin
        p_sub_self_r2: assert (!(sub && (a == b)) || (sum == '0))
            else $error("R2: a - a not zero");
        p_ovf_sign_r9: assert (!ovf || (sum[W-1] != a[W-1]))
            else $error("R9: overflow without sign change");
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR, XOR or NOR of two words, chosen by a 2-bit code.
// Assumes the alu_pkg logic encoding.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  alu_pkg::logfn_e fn,
    output logic [W-1:0]   y
);
    import alu_pkg::*;

    // Function select.
    always_comb begin
        unique case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

    // NOR output may not share a set bit with either operand.
    always_comb begin
        p_nor_disjoint_r3: assert (!(fn == LF_NOR) || ((y & (a | b)) == '0))
            else $error("R3: NOR overlaps operands");
    end
endmodule

// File: rtl/alu_shifter.sv
// Log-stage barrel shifter: stage i moves the word by 2**i when amt[i] is set.
// Assumes W is a power of two and SW = log2(W); kind NONE passes din through.
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SW-1:0]   amt,
    input  alu_pkg::shkind_e kind,
    output logic [W-1:0]    dout
);
    import alu_pkg::*;

    logic         go_right;
    logic         fill;
    logic [W-1:0] cur;

    // Direction and fill value for vacated positions.
    always_comb begin
        go_right = (kind == SK_SRL) || (kind == SK_SRA);
        fill     = (kind == SK_SRA) && din[W-1];
    end

    // Cascade of power-of-two multiplexer stages.
    always_comb begin
        cur = din;
        for (int i = 0; i < SW; i++) begin
            if (amt[i]) begin
                if (go_right)
                    cur = (cur >> (1 << i)) | (fill ? ~({W{1'b1}} >> (1 << i)) : '0);
                else
                    cur = cur << (1 << i);
            end
        end
        dout = (kind == SK_NONE) ? din : cur;
    end

    // Sign fill, zero fill and pass-through guards.
    always_comb begin
        p_sra_fill_r5: assert (!(kind == SK_SRA && din[W-1]) || dout[W-1])
            else $error("R5: sign not replicated");
        p_sll_low_r4: assert (!(kind == SK_SLL && amt != '0) || !dout[0])
            else $error("R4: left shift did not zero-fill");
        p_pass_r4: assert (!(kind == SK_NONE) || (dout == din))
            else $error("R4: no-shift altered data");
    end
endmodule

// File: rtl/int_alu_core.sv
// Top: decodes the control word, runs the three sections in parallel and selects the result.
// Assumes purely combinational use; flags follow the selected result.
module int_alu_core #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [7:0]    ctrl,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [SW-1:0] shamt_imm,
    output logic [W-1:0]  result,
    output logic          zero,
    output logic          ovf
);
    import alu_pkg::*;

    ctrl_t         c;
    logic [W-1:0]  arith_y;
    logic [W-1:0]  logic_y;
    logic [W-1:0]  shift_y;
    logic          arith_ovf;
    logic [SW-1:0] amt;

    // Field split of the control word.
    always_comb c = ctrl_t'(ctrl);

    // Shift count source: constant field or low bits of opa.
    always_comb amt = c.var_amt ? opa[SW-1:0] : shamt_imm;

    alu_addsub #(.W(W)) i_addsub (
        .a(opa), .b(opb), .sub(c.sub), .sum(arith_y), .ovf(arith_ovf)
    );

    alu_logic #(.W(W)) i_logic (
        .a(opa), .b(opb), .fn(c.lfn), .y(logic_y)
    );

    alu_shifter #(.W(W), .SW(SW)) i_shifter (
        .din(opb), .amt(amt), .kind(c.kind), .dout(shift_y)
    );

    // Result multiplexer by function class.
    always_comb begin
        unique case (c.cls)
            CLS_ARITH: result = arith_y;
            CLS_LOGIC: result = logic_y;
            CLS_SHIFT: result = shift_y;
            default:   result = '0;
        endcase
    end

    // Flags: zero detect and class-gated overflow.
    always_comb begin
        zero = ~|result;
        ovf  = (c.cls == CLS_ARITH) && arith_ovf;
    end

    // Flag and reserved-class guards.
    always_comb begin
        p_ovf_class_r9: assert (!ovf || (c.cls == CLS_ARITH))
            else $error("R9: overflow outside arithmetic class");
        p_rsvd_zero_r7: assert (!(c.cls == CLS_RSVD) || zero)
            else $error("R7: reserved class not zero");
        p_zero_r8: assert (!zero || !(c.cls == CLS_LOGIC && c.lfn == LF_OR && (opa | opb) != '0))
            else $error("R8: zero flag with nonzero OR");
    end
endmodule

// File: tb/test_int_alu_core.sv
module test_int_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt_imm = '0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    int_alu_core i_int_alu_core (
        .ctrl(ctrl), .opa(opa), .opb(opb), .shamt_imm(shamt_imm),
        .result(result), .zero(zero), .ovf(ovf)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  c;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  imm;
        logic [31:0] y;
        logic        z;
        logic        v;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 8'h00, 32'd5,          32'd7,          5'd0,  32'd12,         1'b0, 1'b0}, // R1 add
        '{4'd2, 8'h20, 32'd7,          32'd7,          5'd0,  32'd0,          1'b1, 1'b0}, // R2 sub to zero
        '{4'd9, 8'h00, 32'h7FFFFFFF,   32'd1,          5'd0,  32'h80000000,   1'b0, 1'b1}, // R9 add overflow
        '{4'd9, 8'h20, 32'h80000000,   32'd1,          5'd0,  32'h7FFFFFFF,   1'b0, 1'b1}, // R9 sub overflow
        '{4'd2, 8'h20, 32'd3,          32'd5,          5'd0,  32'hFFFFFFFE,   1'b0, 1'b0}, // R2 negative diff
        '{4'd3, 8'h40, 32'hF0F000FF,   32'hFF000F0F,   5'd0,  32'hF000000F,   1'b0, 1'b0}, // R3 AND
        '{4'd3, 8'h41, 32'hF0F000FF,   32'hFF000F0F,   5'd0,  32'hFFF00FFF,   1'b0, 1'b0}, // R3 OR
        '{4'd3, 8'h42, 32'hF0F000FF,   32'hFF000F0F,   5'd0,  32'h0FF00FF0,   1'b0, 1'b0}, // R3 XOR
        '{4'd3, 8'h43, 32'hF0F000FF,   32'hFF000F0F,   5'd0,  32'h000FF000,   1'b0, 1'b0}, // R3 NOR
        '{4'd4, 8'h84, 32'd0,          32'd1,          5'd31, 32'h80000000,   1'b0, 1'b0}, // R4 sll by 31
        '{4'd4, 8'h88, 32'd0,          32'h80000000,   5'd4,  32'h08000000,   1'b0, 1'b0}, // R4 srl
        '{4'd5, 8'h8C, 32'd0,          32'h80000000,   5'd4,  32'hF8000000,   1'b0, 1'b0}, // R5 sra negative
        '{4'd5, 8'h8C, 32'd0,          32'h40000000,   5'd30, 32'd1,          1'b0, 1'b0}, // R5 sra positive
        '{4'd5, 8'h8C, 32'd0,          32'h80000000,   5'd31, 32'hFFFFFFFF,   1'b0, 1'b0}, // R5 sra by 31
        '{4'd6, 8'h94, 32'h00000023,   32'h11,         5'd0,  32'h88,         1'b0, 1'b0}, // R6 variable, high bits ignored
        '{4'd6, 8'h9C, 32'hFFFFFFE1,   32'hFFFFFFF0,   5'd9,  32'hFFFFFFF8,   1'b0, 1'b0}, // R6 variable sra, imm ignored
        '{4'd4, 8'h80, 32'd0,          32'h12345678,   5'd7,  32'h12345678,   1'b0, 1'b0}, // R4 no-shift kind
        '{4'd4, 8'h88, 32'd0,          32'hDEADBEEF,   5'd0,  32'hDEADBEEF,   1'b0, 1'b0}, // R4 count zero
        '{4'd7, 8'hC0, 32'd5,          32'd7,          5'd3,  32'd0,          1'b1, 1'b0}, // R7 reserved class
        '{4'd9, 8'h40, 32'h7FFFFFFF,   32'h7FFFFFFF,   5'd0,  32'h7FFFFFFF,   1'b0, 1'b0}  // R9 no ovf in logic class
    };

    task automatic check(input string tag, input logic [31:0] ey, input logic ez, input logic ev);
        checks++;
        if (result !== ey || zero !== ez || ovf !== ev) begin
            errors++;
            $display("FAIL %s: result=%h zero=%b ovf=%b expected result=%h zero=%b ovf=%b",
                     tag, result, zero, ovf, ey, ez, ev);
        end
    endtask

    task automatic apply(input logic [7:0] c, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] imm);
        @(posedge clk);
        ctrl = c; opa = a; opb = b; shamt_imm = imm;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R8 idle state: all-zero inputs add to zero
        apply(8'h00, 32'd0, 32'd0, 5'd0);
        check("R8 idle zero", 32'd0, 1'b1, 1'b0);
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].c, VECS[k].a, VECS[k].b, VECS[k].imm);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].y, VECS[k].z, VECS[k].v);
        end
        // R8 zero flag from a shift result
        apply(8'h88, 32'd0, 32'd1, 5'd1);
        check("R8 shift to zero", 32'd0, 1'b1, 1'b0);
        // R1 subtract bit ignored outside arithmetic class
        apply(8'h60, 32'h0000FFFF, 32'h00FF00FF, 5'd0);
        check("R1 sub bit in logic class", 32'h000000FF, 1'b0, 1'b0);
        // R6 constant count ignores opa
        apply(8'h84, 32'h0000001F, 32'd3, 5'd2);
        check("R6 constant count", 32'd12, 1'b0, 1'b0);
        // R2 most negative minus itself
        apply(8'h20, 32'h80000000, 32'h80000000, 5'd0);
        check("R2 min minus min", 32'd0, 1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule